// File: doc/BRIEF.md
# Triggered Trace Capture

This block is an on-chip debug recorder. It watches a wide vector of internal probe signals and, at build time, is told which contiguous slice of that vector is worth keeping. Software or a debug controller first arms it. Once armed, it waits for a masked trigger pattern on the full probe vector. From the trigger cycle onward it writes the chosen slice into a small FIFO, and it stops writing when the FIFO is full.

Two capture modes are selected by an input. Continuous mode records one sample on every clock. Change-only mode records a sample only when the slice differs from the last sample stored. The change-only mode stretches the same storage over much longer stretches of activity.

Once full, the recording is frozen until a host drains it through a valid/ready read port, oldest sample first. Emptying the buffer returns the block to idle. A new arm pulse discards whatever is stored and starts over.

Top module: `trace_capture`

## Requirements
- R1: After reset, status_o reads 0 (idle) and rd_valid_o is 0.
- R2: An arm_i pulse in any state empties the storage, and status_o reads 1 (armed) on the following cycle.
- R3: While armed, nothing is stored until the first clock where (probe_i & trig_mask_i) == (trig_value_i & trig_mask_i). The slice taken on that clock is stored as the first entry, and status_o then reads 2 (capturing).
- R4: Only probe_i[SLICE_LSB +: SLICE_W] is stored. Probe bits outside that slice never change a stored value or the change detection.
- R5: With mode_i = 0 (continuous), one sample is stored on every clock from the trigger cycle until the buffer is full.
- R6: With mode_i = 1 (change-only), after the trigger sample a sample is stored only on clocks where the slice differs from the most recently stored sample.
- R7: Once DEPTH samples are stored, status_o reads 3 (full) and further probe activity stores nothing. No stored sample is overwritten.
- R8: rd_valid_o is 1 only while status_o reads 3. rd_data_o shows the oldest unread sample and holds it while rd_ready_i is 0. One sample is removed per clock with rd_valid_o and rd_ready_i both high. Removing the last sample returns status_o to 0.
- R9: In idle, a matching trigger pattern starts nothing: status_o stays 0.
- R10: An arm_i pulse while full discards the stored samples, so a later readout returns only samples from the new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_i | input | PROBE_W | Debug probe vector |
| trig_mask_i | input | PROBE_W | Bits that take part in the trigger compare |
| trig_value_i | input | PROBE_W | Pattern compared under the mask |
| mode_i | input | 1 | 0 = store every clock, 1 = store on change only |
| arm_i | input | 1 | Clear storage and wait for trigger |
| status_o | output | 2 | 0 idle, 1 armed, 2 capturing, 3 full |
| rd_valid_o | output | 1 | A stored sample is available |
| rd_ready_i | input | 1 | Host accepts the sample on this clock |
| rd_data_o | output | SLICE_W | Oldest unread sample |

## Verification
The bench builds the block with a 16-bit probe, an 8-bit slice starting at bit 4 and a depth of only 4. With this shallow buffer, every 8-sample stimulus stream runs past the full point, so the freeze behaviour is exercised on each scenario. Because the slice sits in the middle of the probe, the bench can toggle bits on both sides of it and show that they neither enter storage nor count as a change. Placing the trigger at the first sample and part way through a stream covers both an immediate trigger and a delayed one.

// File: rtl/trace_cap_pkg.sv
package trace_cap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_FULL  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/trace_match.sv
module trace_match #(
  parameter int PROBE_W = 32
) (
  input  logic [PROBE_W-1:0] probe_i,
  input  logic [PROBE_W-1:0] mask_i,
  input  logic [PROBE_W-1:0] value_i,
  output logic               hit_o
);
  logic [PROBE_W-1:0] bit_ok;

  // per-bit agreement, masked-out bits always agree
  for (genvar b = 0; b < PROBE_W; b++) begin : g_bit
    assign bit_ok[b] = ~mask_i[b] | ~(probe_i[b] ^ value_i[b]);
  end

  assign hit_o = &bit_ok;
endmodule

// File: rtl/trace_ref.sv
module trace_ref #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  output logic         differs_o
);
  logic [W-1:0] ref_q, ref_d;

  always_comb begin
    ref_d = ref_q;
    if (clr_i)       ref_d = '0;
    else if (load_i) ref_d = din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '0;
    else        ref_q <= ref_d;
  end

  assign differs_o = (din_i != ref_q);

  // R6: after a load, the held reference equals the loaded slice
  a_r6_ref_tracks_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> (ref_q == $past(din_i)));
endmodule

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full && !clr_i;
  assign pop_ok  = pop_i && !empty_o && !clr_i;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clr_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = step(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = step(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage array: write-enabled, no reset needed
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= din_i;
  end

  assign dout_o = mem_q[rd_ptr_q];
  assign cnt_o  = cnt_q;

  // R2: a clear leaves the storage empty
  a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> empty_o);
  // R7: a full buffer keeps its occupancy unless read or cleared
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop_i && !clr_i) |=> $stable(cnt_q));
  // R7: occupancy never exceeds the depth
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R8: an accepted read without a write removes exactly one sample
  a_r8_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !clr_i && !empty_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_cap_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          hit_i,
  input  logic          mode_i,
  input  logic          differs_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          rd_ready_i,
  output logic          clr_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          rd_valid_o,
  output cap_state_e    state_o
);
  cap_state_e state_q, state_d;
  logic       last_slot;
  logic       want_sample;

  assign last_slot   = (cnt_i == CW'(DEPTH - 1));
  assign want_sample = !mode_i || differs_i;
  assign clr_o       = arm_i;
  assign rd_valid_o  = (state_q == ST_FULL) && (cnt_i != '0);
  assign pop_o       = rd_valid_o && rd_ready_i && !arm_i;

  always_comb begin
    state_d = state_q;
    push_o  = 1'b0;
    if (arm_i) begin
      state_d = ST_ARMED;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_ARMED: begin
          if (hit_i) begin
            push_o  = 1'b1;
            state_d = (DEPTH == 1) ? ST_FULL : ST_CAPT;
          end
        end
        ST_CAPT: begin
          if (want_sample) begin
            push_o = 1'b1;
            if (last_slot) state_d = ST_FULL;
          end
        end
        ST_FULL: begin
          if (pop_o && cnt_i == CW'(1)) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R9: idle never writes to storage
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !push_o);
  // R3: writes only happen while armed or capturing
  a_r3_push_window: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> (state_q == ST_ARMED || state_q == ST_CAPT));
  // R6: unchanged slice in change-only mode is not stored
  a_r6_skip_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAPT && mode_i && !differs_i) |-> !push_o);
  // R7: full state has storage at capacity until the first read
  a_r7_full_count: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(state_q == ST_FULL)) |-> (cnt_i == CW'(DEPTH)));
  // R8: draining the last sample returns to idle
  a_r8_drain_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FULL && cnt_i == '0) |-> (state_q == ST_IDLE || arm_i) || $past(arm_i));
endmodule

// File: rtl/trace_capture.sv
module trace_capture
  import trace_cap_pkg::*;
#(
  parameter int PROBE_W   = 32,
  parameter int SLICE_LSB = 8,
  parameter int SLICE_W   = 16,
  parameter int DEPTH     = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic [PROBE_W-1:0] trig_mask_i,
  input  logic [PROBE_W-1:0] trig_value_i,
  input  logic               mode_i,
  input  logic               arm_i,
  output logic [1:0]         status_o,
  output logic               rd_valid_o,
  input  logic               rd_ready_i,
  output logic [SLICE_W-1:0] rd_data_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [SLICE_W-1:0] slice;
  logic               hit, differs, clr, push, pop, empty;
  logic [CW-1:0]      cnt;
  cap_state_e         state;

  assign slice = probe_i[SLICE_LSB +: SLICE_W];

  trace_match #(.PROBE_W(PROBE_W)) u_match (
    .probe_i (probe_i),
    .mask_i  (trig_mask_i),
    .value_i (trig_value_i),
    .hit_o   (hit)
  );

  trace_ref #(.W(SLICE_W)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr),
    .load_i    (push),
    .din_i     (slice),
    .differs_o (differs)
  );

  trace_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .hit_i      (hit),
    .mode_i     (mode_i),
    .differs_i  (differs),
    .cnt_i      (cnt),
    .rd_ready_i (rd_ready_i),
    .clr_o      (clr),
    .push_o     (push),
    .pop_o      (pop),
    .rd_valid_o (rd_valid_o),
    .state_o    (state)
  );

  trace_fifo #(.W(SLICE_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .push_i  (push),
    .din_i   (slice),
    .pop_i   (pop),
    .dout_o  (rd_data_o),
    .cnt_o   (cnt),
    .empty_o (empty)
  );

  assign status_o = state;

  // R8: valid data is offered only while full
  a_r8_valid_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (status_o == 2'd3 && !empty));
  // R8: offered data holds while the host stalls
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i && !arm_i) |=> $stable(rd_data_o));
endmodule

// File: tb/tb_trace_capture.sv
module tb_trace_capture;
  localparam int PW  = 16;
  localparam int LSB = 4;
  localparam int SW  = 8;
  localparam int DEP = 4;

  typedef struct packed {
    logic            mode;
    logic [15:0]     mask;
    logic [15:0]     value;
    logic [0:7][15:0] p;
  } row_t;

  localparam row_t ROWS [4] = '{
    '{1'b0, 16'hF000, 16'h3000,
      {16'h1111, 16'h2222, 16'h3456, 16'h4567, 16'h5678, 16'h6789, 16'h789A, 16'h89AB}},
    '{1'b1, 16'h000F, 16'h0005,
      {16'h0015, 16'h0016, 16'hF01A, 16'h0020, 16'h0021, 16'h0010, 16'h0FF0, 16'h0000}},
    '{1'b0, 16'h0000, 16'h0000,
      {16'hA5A0, 16'h0000, 16'hFFFF, 16'h1230, 16'h4440, 16'h5550, 16'h6660, 16'h7770}},
    '{1'b1, 16'hFFFF, 16'hBEEF,
      {16'hBEEE, 16'hBEEF, 16'hBEEF, 16'hCEEF, 16'h0100, 16'h0110, 16'h0120, 16'h0000}}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [PW-1:0] probe, tmask, tvalue;
  logic          mode, arm, rd_ready, rd_valid;
  logic [1:0]    status;
  logic [SW-1:0] rd_data;
  int            n_tests = 0;
  int            n_fail  = 0;

  always #2 clk = ~clk;

  trace_capture #(.PROBE_W(PW), .SLICE_LSB(LSB), .SLICE_W(SW), .DEPTH(DEP)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .probe_i      (probe),
    .trig_mask_i  (tmask),
    .trig_value_i (tvalue),
    .mode_i       (mode),
    .arm_i        (arm),
    .status_o     (status),
    .rd_valid_o   (rd_valid),
    .rd_ready_i   (rd_ready),
    .rd_data_o    (rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_arm(input logic m, input logic [PW-1:0] mk, input logic [PW-1:0] vl);
    mode = m; tmask = mk; tvalue = vl; arm = 1'b1;
    tick();
    arm = 1'b0;
    check("R2 armed after arm", status, 2'd1);
  endtask

  task automatic drain(input logic [3:0][7:0] e, input string req);
    rd_ready = 1'b0;
    tick();
    check("R7 still full", status, 2'd3);
    check("R8 valid in full", rd_valid, 1'b1);
    check({req, " stall holds oldest"}, rd_data, e[0]);
    for (int k = 0; k < DEP; k++) begin
      check({req, " readout order"}, rd_data, e[k]);
      rd_ready = 1'b1;
      tick();
    end
    rd_ready = 1'b0;
    check("R8 idle after drain", status, 2'd0);
    check("R8 no valid after drain", rd_valid, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; probe = '0; tmask = '0; tvalue = '0;
    mode = 1'b0; arm = 1'b0; rd_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset status", status, 2'd0);
    check("R1 reset valid", rd_valid, 1'b0);

    // R9: matching pattern while idle
    probe = 16'h1234;
    repeat (3) tick();
    check("R9 idle ignores trigger", status, 2'd0);
    check("R9 idle no data", rd_valid, 1'b0);

    // table-driven captures
    for (int r = 0; r < 4; r++) begin
      logic [3:0][7:0] exp_q;
      int   cnt;
      logic trig;
      logic [7:0] last;
      logic [7:0] sl;
      logic [1:0] est;
      exp_q = '0; cnt = 0; trig = 1'b0; last = '0;
      probe = '0;
      do_arm(ROWS[r].mode, ROWS[r].mask, ROWS[r].value);
      for (int i = 0; i < 8; i++) begin
        probe = ROWS[r].p[i];
        sl = probe[LSB +: SW];
        if (!trig) begin
          if ((probe & ROWS[r].mask) == (ROWS[r].value & ROWS[r].mask)) begin
            trig = 1'b1; exp_q[cnt] = sl; cnt++; last = sl;
          end
        end else if (cnt < DEP) begin
          if (!ROWS[r].mode || sl != last) begin
            exp_q[cnt] = sl; cnt++; last = sl;
          end
        end
        tick();
        est = !trig ? 2'd1 : (cnt == DEP) ? 2'd3 : 2'd2;
        check(ROWS[r].mode ? "R3/R6/R7 status" : "R3/R5/R7 status", status, est);
      end
      drain(exp_q, ROWS[r].mode ? "R4 R6" : "R4 R5");
    end

    // R10: re-arm while full discards old samples
    do_arm(1'b0, 16'h0000, 16'h0000);
    foreach (ROWS[0].p[i]) begin
      if (i < 4) begin
        probe = 16'h0110 * 16'(i + 1);
        tick();
      end
    end
    check("R10 full before re-arm", status, 2'd3);
    do_arm(1'b1, 16'h0000, 16'h0000);
    check("R10 no valid after re-arm", rd_valid, 1'b0);
    probe = 16'h0990; tick();
    probe = 16'h0990; tick();
    probe = 16'h0AA0; tick();
    probe = 16'h0990; tick();
    probe = 16'h0BB0; tick();
    check("R10 new capture full", status, 2'd3);
    drain({8'hBB, 8'h99, 8'hAA, 8'h99}, "R10 R6");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule